// File: doc/BRIEF.md
# Majority-Vote Register Read Filter

This block turns reads of an unreliable register into reliable reads. A single request makes it sample the source register once per clock, up to a fixed number of times, and answer with the value that came back most often. Any wrong value that the source returns now and then is outvoted by the value it returns most of the time.

While a read runs, the block keeps a table of the distinct values it has seen, each with its own occurrence count. It also tracks a leader: the value with the highest count so far. The leader changes only when a count rises strictly above the leader's count, so of two values with equal counts, the one that reached that count first stays the leader. As soon as the leader's count is more than half of the sample budget, no other value can catch up, and the read ends early. The requester sees `busy_o` from the cycle after its request until a one-cycle `resp_valid_o` pulse delivers the answer on `resp_data_o`.

Top module: `mvote_read_filter`

## Requirements
- R1: While reset is held, and right after it is released, `busy_o`, `resp_valid_o` and `src_rd_o` are all 0.
- R2: A `req_i` seen at a clock edge while the block is idle starts a read. From the next cycle, `busy_o` and `src_rd_o` are 1, and the block takes exactly one sample of `src_data_i` at each edge for as long as `src_rd_o` is 1.
- R3: If no value gets a strict majority, the read takes exactly NUM_SAMPLES samples (100 by default).
- R4: The read stops after the first sample that lifts any value's count above NUM_SAMPLES/2 (a count of 51 by default). A source that returns one constant value therefore takes 51 samples.
- R5: The value returned is the one that occurred most often among the samples taken.
- R6: When two values have equal counts, the one that reached that count first is returned. A value that later goes strictly above the leader's count becomes the new leader.
- R7: The cycle after the last sample, `resp_valid_o` is 1 for exactly one cycle, and `busy_o` is still 1 in that cycle. In the next cycle `busy_o` is 0, so `busy_o` is high for the number of samples plus one cycle.
- R8: A `req_i` that arrives while `busy_o` is 1 is ignored. It does not lengthen or restart the current read, and it does not cause a second response.
- R9: Each read starts with an empty value table and a zero leader count, so values seen in an earlier read have no effect on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read request, acted on only when the block is idle |
| busy_o | output | 1 | A read is in progress, up to and including the response cycle |
| resp_valid_o | output | 1 | One-cycle pulse that marks the filtered result |
| resp_data_o | output | DATA_W | Filtered result; 0 when no response is being given |
| src_rd_o | output | 1 | The block samples the source at this cycle's edge |
| src_data_i | input | DATA_W | Raw value read from the unreliable register |

## Verification
The bench builds the block with its default parameters: 32-bit data and a budget of 100 samples. Because 100 is even, a source that alternates between two values ends in an exact 50/50 tie, so the tie rule is tested with each of the two values arriving first. Sources that settle after a run of noise, that hand the lead from one value to another, or that return a wrong value on every third sample land the early stop on a different sample index each time. A source that returns a new value on every sample fills the whole table and forces the full 100-sample read.

// File: rtl/mvote_pkg.sv
package mvote_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_REPLY  = 2'd2
  } mv_state_e;

  // A candidate displaces the leader only when strictly ahead.
  function automatic logic beats_leader(input int unsigned cand,
                                        input int unsigned lead);
    return cand > lead;
  endfunction

  // A count above half the budget can no longer be overtaken.
  function automatic logic is_majority(input int unsigned cnt,
                                       input int unsigned total);
    return cnt > (total / 2);
  endfunction

endpackage

// File: rtl/mvote_table.sv
module mvote_table
  import mvote_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 100,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample_en,
  input  logic [DATA_W-1:0] sample_data,
  output logic [CNT_W-1:0]  cand_cnt,
  output logic              new_entry
);

  localparam int USED_W = $clog2(DEPTH + 1);

  logic [USED_W-1:0] used_q;
  logic [DEPTH-1:0]  match;
  logic [CNT_W-1:0]  hit_part [DEPTH];
  logic              any_hit;

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_ent
      logic [DATA_W-1:0] val_q;
      logic [CNT_W-1:0]  cnt_q;
      logic              live;

      assign live      = (USED_W'(gi) < used_q);
      assign match[gi] = live && (val_q == sample_data);
      // Distinct entries: at most one part is non-zero.
      assign hit_part[gi] = match[gi] ? (cnt_q + CNT_W'(1)) : '0;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          val_q <= '0;
          cnt_q <= '0;
        end else if (clear) begin
          cnt_q <= '0;
        end else if (sample_en) begin
          if (match[gi]) begin
            cnt_q <= cnt_q + CNT_W'(1);
          end else if (!any_hit && (used_q == USED_W'(gi))) begin
            val_q <= sample_data;
            cnt_q <= CNT_W'(1);
          end
        end
      end
    end
  endgenerate

  assign any_hit   = |match;
  assign new_entry = sample_en && !any_hit;

  always_comb begin
    logic [CNT_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < DEPTH; k++) begin
      acc = acc | hit_part[k];
    end
    cand_cnt = any_hit ? acc : CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
    end else if (clear) begin
      used_q <= '0;
    end else if (new_entry && (used_q < USED_W'(DEPTH))) begin
      used_q <= used_q + USED_W'(1);
    end
  end

endmodule

// File: rtl/mvote_leader.sv
module mvote_leader
  import mvote_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_SAMPLES = 100,
  parameter int CNT_W       = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample_en,
  input  logic [CNT_W-1:0]  cand_cnt,
  input  logic [DATA_W-1:0] cand_val,
  output logic [CNT_W-1:0]  lead_cnt,
  output logic [DATA_W-1:0] lead_val,
  output logic              lead_change,
  output logic              majority
);

  logic [CNT_W-1:0] next_cnt;

  assign lead_change = sample_en &&
                       beats_leader(32'(cand_cnt), 32'(lead_cnt));
  assign next_cnt    = lead_change ? cand_cnt : lead_cnt;
  assign majority    = sample_en &&
                       is_majority(32'(next_cnt), 32'(NUM_SAMPLES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_cnt <= '0;
      lead_val <= '0;
    end else if (clear) begin
      lead_cnt <= '0;
      lead_val <= '0;
    end else if (lead_change) begin
      lead_cnt <= cand_cnt;
      lead_val <= cand_val;
    end
  end

endmodule

// File: rtl/mvote_ctrl.sv
module mvote_ctrl
  import mvote_pkg::*;
#(
  parameter int NUM_SAMPLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic majority,
  output logic clear,
  output logic sample_en,
  output logic last_sample,
  output logic busy,
  output logic reply
);

  localparam int SMP_W = $clog2(NUM_SAMPLES + 1);

  mv_state_e        state_q;
  logic [SMP_W-1:0] smp_q;

  assign clear       = (state_q == ST_IDLE) && req;
  assign sample_en   = (state_q == ST_SAMPLE);
  assign last_sample = sample_en &&
                       (majority || (smp_q == SMP_W'(NUM_SAMPLES - 1)));
  assign busy        = (state_q != ST_IDLE);
  assign reply       = (state_q == ST_REPLY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      smp_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          smp_q <= '0;
          if (req) state_q <= ST_SAMPLE;
        end
        ST_SAMPLE: begin
          smp_q <= smp_q + SMP_W'(1);
          if (last_sample) state_q <= ST_REPLY;
        end
        ST_REPLY: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mvote_read_filter.sv
module mvote_read_filter
  import mvote_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_SAMPLES = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  output logic              busy_o,
  output logic              resp_valid_o,
  output logic [DATA_W-1:0] resp_data_o,
  output logic              src_rd_o,
  input  logic [DATA_W-1:0] src_data_i
);

  localparam int CNT_W = $clog2(NUM_SAMPLES + 1);

  // Internal events, named for the bound checker.
  logic             ev_clear;
  logic             ev_sample;
  logic             ev_last;
  logic             ev_new_entry;
  logic             ev_lead_change;
  logic             ev_majority;
  logic [CNT_W-1:0] cand_cnt;
  logic [CNT_W-1:0] lead_cnt;
  logic [DATA_W-1:0] lead_val;
  logic             reply;

  mvote_ctrl #(.NUM_SAMPLES(NUM_SAMPLES)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req_i),
    .majority    (ev_majority),
    .clear       (ev_clear),
    .sample_en   (ev_sample),
    .last_sample (ev_last),
    .busy        (busy_o),
    .reply       (reply)
  );

  mvote_table #(.DATA_W(DATA_W), .DEPTH(NUM_SAMPLES), .CNT_W(CNT_W)) u_table (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (ev_clear),
    .sample_en   (ev_sample),
    .sample_data (src_data_i),
    .cand_cnt    (cand_cnt),
    .new_entry   (ev_new_entry)
  );

  mvote_leader #(.DATA_W(DATA_W), .NUM_SAMPLES(NUM_SAMPLES), .CNT_W(CNT_W)) u_leader (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (ev_clear),
    .sample_en   (ev_sample),
    .cand_cnt    (cand_cnt),
    .cand_val    (src_data_i),
    .lead_cnt    (lead_cnt),
    .lead_val    (lead_val),
    .lead_change (ev_lead_change),
    .majority    (ev_majority)
  );

  assign src_rd_o     = ev_sample;
  assign resp_valid_o = reply;
  assign resp_data_o  = reply ? lead_val : '0;

endmodule

// File: rtl/mvote_read_filter_chk.sv
module mvote_read_filter_chk #(
  parameter int NUM_SAMPLES = 100,
  parameter int CNT_W       = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req,
  input logic             busy,
  input logic             valid,
  input logic             src_rd,
  input logic             majority,
  input logic [CNT_W-1:0] lead_cnt
);

  localparam int RUN_W = $clog2(NUM_SAMPLES + 2);
  logic [RUN_W-1:0] rd_run;

  always_ff @(posedge clk) begin
    if (!rst_n || !src_rd) rd_run <= '0;
    else                   rd_run <= rd_run + RUN_W'(1);
  end

  assert_idle_outputs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!valid && !src_rd));

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req) |=> (busy && src_rd));

  assert_sample_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    src_rd |-> (rd_run < RUN_W'(NUM_SAMPLES)));

  assert_early_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_rd && majority) |=> (valid && !src_rd));

  assert_lead_monotonic_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_rd && $past(src_rd)) |-> (lead_cnt >= $past(lead_cnt)));

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> (!valid && !busy));

  assert_valid_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (busy && !src_rd));

  assert_no_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    src_rd |=> busy);

endmodule

bind mvote_read_filter mvote_read_filter_chk #(
  .NUM_SAMPLES(NUM_SAMPLES),
  .CNT_W      (CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req      (req_i),
  .busy     (busy_o),
  .valid    (resp_valid_o),
  .src_rd   (src_rd_o),
  .majority (ev_majority),
  .lead_cnt (lead_cnt)
);

// File: tb/mvote_read_filter_tb.sv
`timescale 1ns/1ps
module mvote_read_filter_tb;

  localparam int DW = 32;
  localparam int NS = 100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_i = 1'b0;
  logic          busy_o, resp_valid_o, src_rd_o;
  logic [DW-1:0] resp_data_o;
  logic [DW-1:0] src_data_i = '0;

  int checks = 0;
  int failures = 0;
  int cur_pat = 0;

  // Behavioural reference model state
  int          m_state = 0;   // 0 idle, 1 sampling, 2 reply
  int          m_k = 0;
  int          m_max = 0;
  logic [31:0] m_win = '0;
  logic [31:0] vals [$];
  int          cnts [$];

  always #5 clk = ~clk;

  mvote_read_filter #(.DATA_W(DW), .NUM_SAMPLES(NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .busy_o(busy_o),
    .resp_valid_o(resp_valid_o), .resp_data_o(resp_data_o),
    .src_rd_o(src_rd_o), .src_data_i(src_data_i)
  );

  function automatic logic [31:0] pat_val(input int p, input int k);
    case (p)
      0: return 32'hCAFE_0001;
      1: return (k % 2 == 0) ? 32'h1111_0000 : 32'h2222_0000;
      2: return (k % 2 == 0) ? 32'h2222_0000 : 32'h1111_0000;
      3: return 32'h5000_0000 + 32'(k);
      4: return (k < 10) ? 32'h9000_0000 + 32'(k) : 32'h0BAD_F00D;
      5: return (k < 30) ? 32'h0000_0003 : 32'h0000_0004;
      6: return (k % 3 == 2) ? 32'hA000_0000 + 32'(k) : 32'h7777_7777;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Model advance at each edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0;
    end else begin
      case (m_state)
        0: if (req_i) begin
             m_state = 1; m_k = 0; m_max = 0;
             vals.delete(); cnts.delete();
           end
        1: begin
             int j;
             j = -1;
             foreach (vals[q]) if (vals[q] == src_data_i) j = q;
             if (j < 0) begin
               vals.push_back(src_data_i); cnts.push_back(1); j = vals.size() - 1;
             end else begin
               cnts[j] = cnts[j] + 1;
             end
             if (cnts[j] > m_max) begin m_max = cnts[j]; m_win = vals[j]; end
             m_k++;
             if (m_max > NS / 2 || m_k == NS) m_state = 2;
           end
        default: m_state = 0;
      endcase
    end
  end

  // Source drive and per-cycle comparison
  always @(negedge clk) begin
    src_data_i = (m_state == 1) ? pat_val(cur_pat, m_k) : 32'hDEAD_BEEF;
    if (rst_n) begin
      check(busy_o == (m_state != 0), "R2", "busy vs model", 32'(busy_o), 32'(m_state != 0));
      check(src_rd_o == (m_state == 1), "R2", "src_rd vs model", 32'(src_rd_o), 32'(m_state == 1));
      check(resp_valid_o == (m_state == 2), "R7", "valid vs model", 32'(resp_valid_o), 32'(m_state == 2));
      if (m_state == 2)
        check(resp_data_o == m_win, "R5", "data vs model", resp_data_o, m_win);
    end
  end

  task automatic do_read(input int p, input int exp_smp, input logic [31:0] exp_val,
                         input bit pester, input string tag);
    int blen, nval;
    logic [31:0] got;
    blen = 0; nval = 0; got = '0;
    @(negedge clk);
    cur_pat = p; req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    while (busy_o && blen < 300) begin
      blen++;
      if (resp_valid_o) begin nval++; got = resp_data_o; end
      req_i = (pester && (blen % 7 == 3)) ? 1'b1 : 1'b0;
      @(negedge clk);
    end
    req_i = 1'b0;
    check(blen == exp_smp + 1, tag, "busy length (samples+1)", 32'(blen), 32'(exp_smp + 1));
    check(nval == 1, "R7", "response count", 32'(nval), 32'd1);
    check(got == exp_val, tag, "result value", got, exp_val);
    repeat (2) @(negedge clk);
    check(!busy_o && !resp_valid_o, pester ? "R8" : "R7", "idle after reply",
          32'({busy_o, resp_valid_o}), 32'd0);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog: run did not complete");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy_o && !resp_valid_o && !src_rd_o, "R1", "outputs in reset",
          32'({busy_o, resp_valid_o, src_rd_o}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !resp_valid_o && !src_rd_o, "R1", "outputs after reset",
          32'({busy_o, resp_valid_o, src_rd_o}), 32'd0);

    do_read(0, 51,  32'hCAFE_0001, 1'b0, "R4");  // constant source
    do_read(3, 100, 32'h5000_0000, 1'b0, "R9");  // all distinct, fresh table (R3)
    do_read(1, 100, 32'h1111_0000, 1'b0, "R6");  // 50/50 tie, first wins (R3)
    do_read(2, 100, 32'h2222_0000, 1'b0, "R6");  // tie with order swapped
    do_read(4, 61,  32'h0BAD_F00D, 1'b0, "R4");  // noise then settle
    do_read(5, 81,  32'h0000_0004, 1'b0, "R6");  // lead handed over
    do_read(6, 76,  32'h7777_7777, 1'b0, "R5");  // periodic wrong values
    do_read(0, 51,  32'hCAFE_0001, 1'b1, "R8");  // requests while busy ignored

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule